// File: doc/BRIEF.md
# Inrush Wetting Pulse Controller

This block sits behind the sampling converter of an isolated binary input. It watches a stream of 10-bit readings. When a reading climbs to or past a programmable trigger level, it starts a high-current wetting pulse. The pulse cleans the contacts that feed the input. The pulse lasts a programmable number of sample periods. Its current level is also programmable. When the pulse ends, the block drops back to a low bias load on its own. The bias load damps capacitively coupled noise, and it is always present outside a pulse.

The block drives two outputs to the external current-source driver. One is a current-level code. The other is a flag that is high while the inrush pulse runs. Four write-only settings are loaded through a small write port: the trigger level, the pulse code, the pulse length and the bias code. The bias code covers about 50 µA to 3.75 mA, in 50 µA steps. Code k stands for (k+1)·50 µA, so the highest valid bias code is 74.

Top module: `wetting_pulse_ctrl`

## Requirements
- R1: Reset puts the block in bias mode with no pulse running. After reset, `inrush_active` is 0 and `cur_code` equals the reset bias code, 10.
- R2: A write with `cfg_wr` high loads the low bits of `cfg_data` into one setting, chosen by `cfg_sel`. Select 0 loads the 10-bit trigger level, 1 the 7-bit pulse code, 2 the 8-bit pulse length and 3 the 7-bit bias code. The new value is in force from the next clock edge.
- R3: A trigger occurs on a valid sample at or above the trigger level when the previous valid sample was below it. The first valid sample after reset counts as following a below-level reading. On a trigger, `inrush_active` rises at the same clock edge that takes in the sample.
- R4: While valid readings stay at or above the level, no new trigger occurs. Re-arming needs a valid sample below the level.
- R5: A pulse of length D ends at the clock edge that takes in the D-th valid sample after the trigger sample. Cycles with `sample_valid` low do not count.
- R6: `cur_code` equals the pulse code captured at the trigger while a pulse runs. At all other times it equals the bias setting.
- R7: Writes to the pulse code or the pulse length during a pulse leave that pulse unchanged. They take effect from the next trigger.
- R8: A bias code write above 74 is stored as 74.
- R9: A trigger with pulse length 0 starts no pulse, but it still uses up the rising crossing.
- R10: A fresh crossing that occurs inside a running pulse neither extends nor restarts that pulse.
- R11: Readings with `sample_valid` low do not re-arm the trigger and cannot trigger a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting select (0 level, 1 pulse code, 2 length, 3 bias) |
| cfg_data | input | 10 | Setting write value |
| sample_valid | input | 1 | A new reading is present this cycle |
| sample | input | 10 | Converter reading |
| inrush_active | output | 1 | High while the wetting pulse runs |
| cur_code | output | 7 | Current-level code for the driver |

## Verification
Every result here appears at the first clock edge after its cause. That covers a trigger from a sample, the end of a pulse on its last counted sample, and a setting write seen at the code output. The bench drives each cycle's inputs just after a falling edge. It compares both outputs at the next falling edge against a model advanced by the same inputs. Each comparison therefore lands exactly one edge after its stimulus. Directed sequences stretch the pulse with gaps in `sample_valid` and cross the level inside a pulse. They also write settings in mid-pulse, use a zero length and saturate the bias. A long seeded random run then mixes readings near the level with random writes.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [1:0] {
        SEL_LEVEL = 2'd0,
        SEL_PULSE = 2'd1,
        SEL_LEN   = 2'd2,
        SEL_BIAS  = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        MODE_BIAS   = 1'b0,
        MODE_INRUSH = 1'b1
    } drive_mode_e;

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs #(
    parameter int ADC_W    = 10,
    parameter int CODE_W   = 7,
    parameter int DUR_W    = 8,
    parameter int DATA_W   = 10,
    parameter int BIAS_MAX = 74,
    parameter int RST_LVL  = 512,
    parameter int RST_PLS  = 40,
    parameter int RST_LEN  = 4,
    parameter int RST_BIAS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADC_W-1:0]  level_o,
    output logic [CODE_W-1:0] pulse_o,
    output logic [DUR_W-1:0]  len_o,
    output logic [CODE_W-1:0] bias_o
);
    import wp_pkg::*;

    localparam logic [CODE_W-1:0] BIAS_CAP = CODE_W'(BIAS_MAX);

    logic [CODE_W-1:0] bias_field;
    logic [CODE_W-1:0] bias_sat;
    cfg_sel_e          sel;

    assign sel        = cfg_sel_e'(wr_sel);
    assign bias_field = wr_data[CODE_W-1:0];
    assign bias_sat   = (bias_field > BIAS_CAP) ? BIAS_CAP : bias_field;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_o <= ADC_W'(RST_LVL);
            pulse_o <= CODE_W'(RST_PLS);
            len_o   <= DUR_W'(RST_LEN);
            bias_o  <= CODE_W'(RST_BIAS);
        end else if (wr_en) begin
            case (sel)
                SEL_LEVEL: level_o <= wr_data[ADC_W-1:0];
                SEL_PULSE: pulse_o <= wr_data[CODE_W-1:0];
                SEL_LEN:   len_o   <= wr_data[DUR_W-1:0];
                SEL_BIAS:  bias_o  <= bias_sat;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/wp_edge_detect.sv
module wp_edge_detect #(
    parameter int ADC_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [ADC_W-1:0] sample,
    input  logic [ADC_W-1:0] level,
    output logic             hit_o
);
    logic armed;
    logic at_or_above;

    assign at_or_above = (sample >= level);
    assign hit_o       = valid && armed && at_or_above;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
        end else if (valid) begin
            armed <= !at_or_above;
        end
    end

endmodule

// File: rtl/wp_pulse_timer.sv
module wp_pulse_timer #(
    parameter int CODE_W = 7,
    parameter int DUR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              hit,
    input  logic [DUR_W-1:0]  len,
    input  logic [CODE_W-1:0] pulse_code,
    output wp_pkg::drive_mode_e mode_o,
    output logic [CODE_W-1:0] held_code_o,
    output logic [DUR_W-1:0]  remain_o
);
    import wp_pkg::*;

    localparam logic [DUR_W-1:0] LAST = DUR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o      <= MODE_BIAS;
            remain_o    <= '0;
            held_code_o <= '0;
        end else begin
            case (mode_o)
                MODE_BIAS: begin
                    if (hit && (len != '0)) begin
                        mode_o      <= MODE_INRUSH;
                        remain_o    <= len;
                        held_code_o <= pulse_code;
                    end
                end
                MODE_INRUSH: begin
                    if (valid) begin
                        if (remain_o == LAST) begin
                            mode_o   <= MODE_BIAS;
                            remain_o <= '0;
                        end else begin
                            remain_o <= remain_o - LAST;
                        end
                    end
                end
                default: mode_o <= MODE_BIAS;
            endcase
        end
    end

endmodule

// File: rtl/wetting_pulse_ctrl.sv
module wetting_pulse_ctrl #(
    parameter int ADC_W    = 10,
    parameter int CODE_W   = 7,
    parameter int DUR_W    = 8,
    parameter int BIAS_MAX = 74,
    parameter int RST_LVL  = 512,
    parameter int RST_PLS  = 40,
    parameter int RST_LEN  = 4,
    parameter int RST_BIAS = 10,
    localparam int DATA_W  = wp_pkg::max_of3(ADC_W, CODE_W, DUR_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              sample_valid,
    input  logic [ADC_W-1:0]  sample,
    output logic              inrush_active,
    output logic [CODE_W-1:0] cur_code
);
    import wp_pkg::*;

    logic [ADC_W-1:0]  level_q;
    logic [CODE_W-1:0] pulse_q;
    logic [DUR_W-1:0]  len_q;
    logic [CODE_W-1:0] bias_q;
    logic              cross_hit;
    drive_mode_e       mode;
    logic [CODE_W-1:0] held_code;
    logic [DUR_W-1:0]  remain;

    wp_cfg_regs #(
        .ADC_W(ADC_W), .CODE_W(CODE_W), .DUR_W(DUR_W), .DATA_W(DATA_W),
        .BIAS_MAX(BIAS_MAX), .RST_LVL(RST_LVL), .RST_PLS(RST_PLS),
        .RST_LEN(RST_LEN), .RST_BIAS(RST_BIAS)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_sel(cfg_sel), .wr_data(cfg_data),
        .level_o(level_q), .pulse_o(pulse_q), .len_o(len_q), .bias_o(bias_q)
    );

    wp_edge_detect #(.ADC_W(ADC_W)) u_edge (
        .clk(clk), .rst(rst), .valid(sample_valid), .sample(sample),
        .level(level_q), .hit_o(cross_hit)
    );

    wp_pulse_timer #(.CODE_W(CODE_W), .DUR_W(DUR_W)) u_timer (
        .clk(clk), .rst(rst), .valid(sample_valid), .hit(cross_hit),
        .len(len_q), .pulse_code(pulse_q),
        .mode_o(mode), .held_code_o(held_code), .remain_o(remain)
    );

    assign inrush_active = (mode == MODE_INRUSH);
    assign cur_code      = inrush_active ? held_code : bias_q;

endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
    parameter int ADC_W    = 10,
    parameter int CODE_W   = 7,
    parameter int DUR_W    = 8,
    parameter int BIAS_MAX = 74
) (
    input logic              clk,
    input logic              rst,
    input logic              sample_valid,
    input logic [ADC_W-1:0]  sample,
    input logic              inrush_active,
    input logic [CODE_W-1:0] cur_code,
    input logic [ADC_W-1:0]  level_q,
    input logic [CODE_W-1:0] bias_q,
    input logic [DUR_W-1:0]  remain
);
    assert_reset_bias_R1: assert property (@(posedge clk)
        $past(rst) |-> !inrush_active);

    assert_start_on_crossing_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(inrush_active) |-> ($past(sample_valid) && ($past(sample) >= $past(level_q))));

    assert_end_on_sample_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(inrush_active) |-> $past(sample_valid));

    assert_count_live_R5: assert property (@(posedge clk) disable iff (rst)
        inrush_active |-> (remain != '0));

    assert_code_held_R7: assert property (@(posedge clk) disable iff (rst)
        (inrush_active && $past(inrush_active)) |-> $stable(cur_code));

    assert_bias_cap_R8: assert property (@(posedge clk) disable iff (rst)
        bias_q <= CODE_W'(BIAS_MAX));

    assert_no_idle_count_R11: assert property (@(posedge clk) disable iff (rst)
        (!sample_valid && inrush_active) |=> (inrush_active && $stable(remain)));
endmodule

bind wetting_pulse_ctrl wp_checker #(
    .ADC_W(ADC_W), .CODE_W(CODE_W), .DUR_W(DUR_W), .BIAS_MAX(BIAS_MAX)
) u_chk (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample(sample),
    .inrush_active(inrush_active), .cur_code(cur_code), .level_q(level_q),
    .bias_q(bias_q), .remain(remain)
);

// File: tb/wetting_pulse_ctrl_tb.sv
module wetting_pulse_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADC_W    = 10;
    localparam int CODE_W   = 7;
    localparam int DUR_W    = 8;
    localparam int DATA_W   = 10;
    localparam int BIAS_MAX = 74;
    localparam int RST_BIAS = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_wr = 1'b0;
    logic [1:0]        cfg_sel = '0;
    logic [DATA_W-1:0] cfg_data = '0;
    logic              sample_valid = 1'b0;
    logic [ADC_W-1:0]  sample = '0;
    logic              inrush_active;
    logic [CODE_W-1:0] cur_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    int m_lvl = 512, m_pls = 40, m_len = 4, m_bias = RST_BIAS;
    int m_act = 0, m_cnt = 0, m_held = 0, m_armed = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    wetting_pulse_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .sample_valid(sample_valid), .sample(sample),
        .inrush_active(inrush_active), .cur_code(cur_code)
    );

    function automatic int exp_code();
        return (m_act != 0) ? m_held : m_bias;
    endfunction

    function automatic int sat_bias(input int d);
        int b;
        b = d & 127;
        return (b > BIAS_MAX) ? BIAS_MAX : b;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit wr, input int sel, input int data, input bit v, input int s);
        bit hit;
        @(negedge clk);
        chk("mode", int'(inrush_active), m_act);
        chk("code", int'(cur_code), exp_code());
        cfg_wr = wr; cfg_sel = 2'(sel); cfg_data = DATA_W'(data);
        sample_valid = v; sample = ADC_W'(s);
        hit = v && (m_armed != 0) && (s >= m_lvl);
        if (m_act == 0) begin
            if (hit && m_len != 0) begin
                m_act = 1; m_cnt = m_len; m_held = m_pls;
            end
        end else if (v) begin
            if (m_cnt == 1) begin m_act = 0; m_cnt = 0; end
            else m_cnt = m_cnt - 1;
        end
        if (v) m_armed = (s < m_lvl) ? 1 : 0;
        if (wr) begin
            case (sel)
                0: m_lvl  = data & 1023;
                1: m_pls  = data & 127;
                2: m_len  = data & 255;
                default: m_bias = sat_bias(data);
            endcase
        end
    endtask

    task automatic wr_cfg(input int sel, input int data);
        cyc(1'b1, sel, data, 1'b0, 0);
    endtask

    task automatic smp(input int s);
        cyc(1'b0, 0, 0, 1'b1, s);
    endtask

    task automatic idle();
        cyc(1'b0, 0, 0, 1'b0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R1"; idle(); idle();

        tag = "R2";
        wr_cfg(0, 300); wr_cfg(1, 50); wr_cfg(2, 3); wr_cfg(3, 20);
        idle();

        tag = "R3";
        smp(100); smp(300); idle();

        tag = "R5";
        smp(400); idle(); idle(); smp(400); idle(); smp(400); idle(); idle();

        tag = "R4";
        smp(500); smp(300); smp(1023); idle();
        smp(299); smp(300); idle();
        smp(300); smp(300); smp(300); idle();

        tag = "R7";
        smp(0); smp(350);
        wr_cfg(1, 5); wr_cfg(2, 1);
        smp(400); smp(400); smp(400); idle();
        smp(10); smp(310); idle(); smp(310); idle();

        tag = "R10";
        wr_cfg(2, 4); wr_cfg(1, 60);
        smp(0); smp(320); smp(10); smp(320); smp(320); smp(320); idle(); idle();

        tag = "R11";
        cyc(1'b0, 0, 0, 1'b0, 0); smp(900); idle();
        smp(0); cyc(1'b0, 0, 0, 1'b0, 900); idle(); smp(900); idle();

        tag = "R9";
        wr_cfg(2, 0); smp(0); smp(800); idle(); smp(800); idle();
        wr_cfg(2, 2); smp(800); idle(); smp(0); smp(800); idle(); smp(1); smp(1); idle();

        tag = "R8";
        wr_cfg(3, 127); idle(); wr_cfg(3, 75); idle();
        wr_cfg(3, 74); idle(); wr_cfg(3, 73); idle(); wr_cfg(3, 0); idle();

        tag = "R6";
        void'($urandom(32'd2024));
        for (int i = 0; i < 6000; i++) begin
            bit wr;
            int sel, data, s;
            wr  = ($urandom % 12) == 0;
            sel = $urandom % 4;
            if (sel == 0) data = 200 + ($urandom % 600);
            else if (sel == 2) data = $urandom % 7;
            else data = $urandom % 128;
            s = m_lvl - 40 + int'($urandom % 80);
            if (s < 0) s = 0;
            if (s > 1023) s = 1023;
            cyc(wr, sel, data, ($urandom % 4) != 0, s);
        end
        idle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule